// File: doc/BRIEF.md
# EPP Cycle Gate

This block is the enhanced-parallel-port slice of a host-side parallel controller. It sits behind a small CPU register window and turns CPU reads and writes of the EPP address slot (offset 3) and the EPP data slot (offset 4) into byte transfers on a generic request/acknowledge peripheral interface. Before launching anything, it checks that the stored control register holds the exact line pattern that an EPP cycle of that direction needs. If the pattern does not match, the access is answered at once and nothing is sent downstream.

Data-slot accesses may be one, two or four bytes wide. Each is broken into single-byte transfers, least-significant byte first, and read bytes are reassembled in the same order. Every byte waits for an acknowledge, up to a programmable number of cycles. A peripheral error or an expired wait ends the transfer early and sets a sticky timeout flag. That flag appears in bit 0 of the status register and is cleared by writing a 1 there. The control register sits in the same window and produces change pulses for the downstream line drivers.

Top module: `epp_cycle_gate`

## Requirements
- R1: An access is accepted on a clock edge where `cpu_req` and `cpu_ready` are both high. Every accepted access produces exactly one `cpu_done` pulse. Status and control accesses, refused EPP accesses and accesses to any offset other than 1 to 4 finish on the cycle after acceptance. Reads of unused offsets return all ones and change no state.
- R2: An EPP write is launched only when the control bits {5 direction, 3 select, 2 init, 1 autofeed, 0 strobe} equal binary 0_0100 (mask 0x2F gives 0x04). Bits outside that mask do not matter. Otherwise the write produces no `pr_req`, and the timeout flag is unchanged.
- R3: An EPP read is launched only when the same masked bits equal 0x24. Otherwise no `pr_req` is raised and `cpu_rdata` is all ones.
- R4: Offset 3 always moves one byte with `pr_addr_cyc`=1, whatever `cpu_size` holds. Offset 4 moves 1, 2 or 4 bytes for `cpu_size` 0, 1 or 2 (size 3 also moves 4 bytes), with `pr_addr_cyc`=0.
- R5: Byte k of a transfer is bits [8k+7:8k]. Bytes are sent in increasing k. A read returns byte k in those bits, and bits above the transferred width are all ones.
- R6: A byte is held on `pr_wdata` with `pr_req` high until `pr_ack`. An acknowledge with `pr_err`=1 is a failure. If no acknowledge arrives by the cycle in which the per-byte wait counter (cleared at each byte start) equals `cfg_timeout`, that is also a failure. A failure abandons the remaining bytes, leaves unreceived read bytes at all ones, and sets the timeout flag.
- R7: A status read returns {24'b0, `line_sts`[7:1], timeout flag}. A status write with bit 0 = 1 clears the flag. A status write with bit 0 = 0 leaves it unchanged.
- R8: Control resets to 0x0C and reads back as {24'b0, control}. A control write with a new value stores it and pulses `ctl_upd` on the cycle after acceptance. A write of the value already held gives no pulse. `ctl_val` is the control value with bit 5 forced to 0.
- R9: `dir_upd` pulses, together with `ctl_upd`, only when a control write changes bit 5. `dir_val` shows bit 5.
- R10: From the acceptance of a launched EPP transfer until its `cpu_done`, `cpu_ready` is low, and any request held during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timeout | input | TMO_W | Per-byte acknowledge wait limit in cycles |
| cpu_req | input | 1 | CPU access request |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register window offset |
| cpu_size | input | 2 | Data-slot width: 0 byte, 1 half, 2/3 word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| line_sts | input | 7 | Live status lines for status bits 7..1 |
| ctl_val | output | 8 | Control value for line drivers, bit 5 cleared |
| dir_val | output | 1 | Stored data-direction bit |
| ctl_upd | output | 1 | Pulse: control value changed |
| dir_upd | output | 1 | Pulse: direction bit changed |
| pr_req | output | 1 | Peripheral byte request |
| pr_wr | output | 1 | Peripheral transfer direction, 1 = write |
| pr_addr_cyc | output | 1 | 1 = address cycle, 0 = data cycle |
| pr_wdata | output | 8 | Byte being written |
| pr_ack | input | 1 | Peripheral acknowledge for the current byte |
| pr_err | input | 1 | Peripheral error, qualified by pr_ack |
| pr_rdata | input | 8 | Byte read, qualified by pr_ack |

## Verification
The bench targets control values one bit away from the legal patterns, and values that differ only outside the mask. A gate that decodes too few or too many bits would launch or drop those cycles, which shows up as a wrong byte count. Wide reads that fail on an inner byte, and acknowledges that arrive exactly at the wait limit or one cycle past it, separate a design that stores bytes out of order, keeps partial data, or is off by one in its timeout. Repeated control writes of the same value, status writes with bit 0 clear, and a request held during a running transfer catch spurious pulses, a flag that clears too easily, and a busy stall that leaks.

// File: rtl/epp_gate_pkg.sv
`timescale 1ns/1ps
package epp_gate_pkg;

    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = DATA_W / BYTE_W;
    localparam int IDX_W   = $clog2(NBYTES);

    localparam logic [2:0] OFS_STS  = 3'd1;
    localparam logic [2:0] OFS_CTL  = 3'd2;
    localparam logic [2:0] OFS_EADR = 3'd3;
    localparam logic [2:0] OFS_EDAT = 3'd4;

    localparam int         CB_DIR         = 5;
    localparam logic [7:0] CTL_GATE_MASK  = 8'h2F;
    localparam logic [7:0] CTL_WR_PATTERN = 8'h04;
    localparam logic [7:0] CTL_RD_PATTERN = 8'h24;
    localparam logic [7:0] CTL_RESET      = 8'h0C;

    typedef enum logic {ENG_IDLE, ENG_XFER} eng_state_e;

    typedef struct packed {
        logic              wr;
        logic              addr_cyc;
        logic [IDX_W-1:0]  last;
        logic [DATA_W-1:0] wdata;
    } xfer_cmd_t;

    function automatic logic gate_ok(input logic [7:0] ctl, input logic wr);
        return (ctl & CTL_GATE_MASK) == (wr ? CTL_WR_PATTERN : CTL_RD_PATTERN);
    endfunction

    function automatic logic [IDX_W-1:0] byte_last(input logic is_addr, input logic [1:0] sz);
        if (is_addr) return '0;
        case (sz)
            2'd0:    return IDX_W'(0);
            2'd1:    return IDX_W'(1);
            default: return IDX_W'(NBYTES - 1);
        endcase
    endfunction

endpackage

// File: rtl/epp_ctl_regs.sv
`timescale 1ns/1ps
module epp_ctl_regs
    import epp_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic       sts_we,
    input  logic [7:0] wdata,
    input  logic       fail_set,
    output logic [7:0] ctl,
    output logic       tmo,
    output logic       ctl_upd,
    output logic       dir_upd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= CTL_RESET;
            tmo     <= 1'b0;
            ctl_upd <= 1'b0;
            dir_upd <= 1'b0;
        end else begin
            ctl_upd <= 1'b0;
            dir_upd <= 1'b0;
            if (ctl_we && (wdata != ctl)) begin
                ctl     <= wdata;
                ctl_upd <= 1'b1;
                dir_upd <= wdata[CB_DIR] != ctl[CB_DIR];
            end
            if (fail_set)
                tmo <= 1'b1;
            else if (sts_we && wdata[0])
                tmo <= 1'b0;
        end
    end

    // R8: a change pulse only follows a real change of the stored value
    assert_upd_real_change_R8: assert property (@(posedge clk) disable iff (rst)
        ctl_upd |-> (ctl != $past(ctl)));

    // R9: direction pulse only when bit 5 flipped
    assert_dir_flip_R9: assert property (@(posedge clk) disable iff (rst)
        dir_upd |-> (ctl[CB_DIR] != $past(ctl[CB_DIR])));

    // R6: the flag only rises after a failure report
    assert_tmo_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo) |-> $past(fail_set));

endmodule

// File: rtl/epp_xfer_engine.sv
`timescale 1ns/1ps
module epp_xfer_engine
    import epp_gate_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cmd_t         cmd,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              pr_ack,
    input  logic              pr_err,
    input  logic [BYTE_W-1:0] pr_rdata,
    output logic              busy,
    output logic              pr_req,
    output logic              pr_wr,
    output logic              pr_addr_cyc,
    output logic [BYTE_W-1:0] pr_wdata,
    output logic              fin,
    output logic              fin_fail,
    output logic [DATA_W-1:0] fin_rdata
);

    eng_state_e        st;
    xfer_cmd_t         cmd_q;
    logic [IDX_W-1:0]  idx;
    logic [TMO_W-1:0]  wait_cnt;
    logic [TMO_W-1:0]  limit_q;
    logic [DATA_W-1:0] rbuf;
    logic              good_ack;
    logic              last_byte;
    logic              expired;

    assign busy        = (st == ENG_XFER);
    assign pr_req      = busy;
    assign pr_wr       = cmd_q.wr;
    assign pr_addr_cyc = cmd_q.addr_cyc;
    assign pr_wdata    = cmd_q.wdata[idx*BYTE_W +: BYTE_W];

    assign good_ack  = busy && pr_ack && !pr_err;
    assign last_byte = (idx == cmd_q.last);
    assign expired   = busy && !pr_ack && (wait_cnt >= limit_q);
    assign fin_fail  = (busy && pr_ack && pr_err) || expired;
    assign fin       = fin_fail || (good_ack && last_byte);

    always_comb begin
        fin_rdata = rbuf;
        if (good_ack && !cmd_q.wr)
            fin_rdata[idx*BYTE_W +: BYTE_W] = pr_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENG_IDLE;
            cmd_q    <= '0;
            idx      <= '0;
            wait_cnt <= '0;
            limit_q  <= '0;
            rbuf     <= '1;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (start) begin
                        st       <= ENG_XFER;
                        cmd_q    <= cmd;
                        idx      <= '0;
                        wait_cnt <= '0;
                        limit_q  <= cfg_timeout;
                        rbuf     <= '1;
                    end
                end
                default: begin
                    if (fin) begin
                        st <= ENG_IDLE;
                    end else if (good_ack) begin
                        rbuf     <= fin_rdata;
                        idx      <= idx + 1'b1;
                        wait_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R6: the byte on offer stays put until it is acknowledged
    assert_byte_held_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(pr_req) && !$past(pr_ack) && pr_req) |-> $stable(pr_wdata));

    // R6: the wait counter never passes the latched limit
    assert_wait_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (wait_cnt <= limit_q));

endmodule

// File: rtl/epp_cycle_gate.sv
`timescale 1ns/1ps
module epp_cycle_gate
    import epp_gate_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [31:0]       cpu_rdata,
    input  logic [7:1]        line_sts,
    output logic [7:0]        ctl_val,
    output logic              dir_val,
    output logic              ctl_upd,
    output logic              dir_upd,
    output logic              pr_req,
    output logic              pr_wr,
    output logic              pr_addr_cyc,
    output logic [7:0]        pr_wdata,
    input  logic              pr_ack,
    input  logic              pr_err,
    input  logic [7:0]        pr_rdata
);

    logic              acc;
    logic              is_epp;
    logic              start;
    logic              ctl_we;
    logic              sts_we;
    logic [7:0]        ctl_q;
    logic              tmo_q;
    logic              eng_busy;
    logic              eng_fin;
    logic              eng_fail;
    logic [DATA_W-1:0] eng_rdata;
    logic [DATA_W-1:0] reg_rdata;
    xfer_cmd_t         cmd;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    assign cpu_ready = !eng_busy;
    assign acc       = cpu_req && cpu_ready;
    assign is_epp    = (cpu_addr == OFS_EADR) || (cpu_addr == OFS_EDAT);
    assign start     = acc && is_epp && gate_ok(ctl_q, cpu_wr);
    assign ctl_we    = acc && cpu_wr && (cpu_addr == OFS_CTL);
    assign sts_we    = acc && cpu_wr && (cpu_addr == OFS_STS);

    always_comb begin
        cmd.wr       = cpu_wr;
        cmd.addr_cyc = (cpu_addr == OFS_EADR);
        cmd.last     = byte_last(cpu_addr == OFS_EADR, cpu_size);
        cmd.wdata    = cpu_wdata;
    end

    epp_ctl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl_we   (ctl_we),
        .sts_we   (sts_we),
        .wdata    (cpu_wdata[7:0]),
        .fail_set (eng_fail),
        .ctl      (ctl_q),
        .tmo      (tmo_q),
        .ctl_upd  (ctl_upd),
        .dir_upd  (dir_upd)
    );

    epp_xfer_engine #(.TMO_W(TMO_W)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cmd         (cmd),
        .cfg_timeout (cfg_timeout),
        .pr_ack      (pr_ack),
        .pr_err      (pr_err),
        .pr_rdata    (pr_rdata),
        .busy        (eng_busy),
        .pr_req      (pr_req),
        .pr_wr       (pr_wr),
        .pr_addr_cyc (pr_addr_cyc),
        .pr_wdata    (pr_wdata),
        .fin         (eng_fin),
        .fin_fail    (eng_fail),
        .fin_rdata   (eng_rdata)
    );

    always_comb begin
        reg_rdata = '1;
        if (!cpu_wr) begin
            case (cpu_addr)
                OFS_STS: reg_rdata = {{(DATA_W-8){1'b0}}, line_sts, tmo_q};
                OFS_CTL: reg_rdata = {{(DATA_W-8){1'b0}}, ctl_q};
                default: reg_rdata = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rdata_q <= '1;
        end else begin
            done_q <= eng_fin || (acc && !start);
            if (eng_fin)
                rdata_q <= eng_rdata;
            else if (acc && !start)
                rdata_q <= reg_rdata;
        end
    end

    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;
    assign ctl_val   = ctl_q & ~(8'd1 << CB_DIR);
    assign dir_val   = ctl_q[CB_DIR];

    // R2: every write transfer begins under the write pattern
    assert_write_gate_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(pr_req) && pr_wr) |-> ((ctl_q & CTL_GATE_MASK) == CTL_WR_PATTERN));

    // R3: every read transfer begins under the read pattern
    assert_read_gate_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(pr_req) && !pr_wr) |-> ((ctl_q & CTL_GATE_MASK) == CTL_RD_PATTERN));

    // R4: an address cycle ends after its single acknowledged byte
    assert_addr_one_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (pr_req && pr_ack && pr_addr_cyc) |=> !pr_req);

    // R6: a failure leaves the sticky flag set
    assert_fail_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        eng_fail |=> tmo_q);

    // R10: control cannot move while a transfer runs
    assert_ctl_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (pr_req && $past(pr_req)) |-> $stable(ctl_q));

endmodule

// File: tb/epp_cycle_gate_test.sv
`timescale 1ns/1ps
module epp_cycle_gate_test;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [TW-1:0] cfg_timeout;
    logic          cpu_req, cpu_wr;
    logic [2:0]    cpu_addr;
    logic [1:0]    cpu_size;
    logic [31:0]   cpu_wdata;
    logic          cpu_ready, cpu_done;
    logic [31:0]   cpu_rdata;
    logic [7:1]    line_sts;
    logic [7:0]    ctl_val;
    logic          dir_val, ctl_upd, dir_upd;
    logic          pr_req, pr_wr, pr_addr_cyc;
    logic [7:0]    pr_wdata;
    logic          pr_ack, pr_err;
    logic [7:0]    pr_rdata;

    always #2.5 clk = ~clk;

    epp_cycle_gate #(.TMO_W(TW)) uut (
        .clk(clk), .rst(rst), .cfg_timeout(cfg_timeout),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .line_sts(line_sts), .ctl_val(ctl_val), .dir_val(dir_val), .ctl_upd(ctl_upd),
        .dir_upd(dir_upd), .pr_req(pr_req), .pr_wr(pr_wr), .pr_addr_cyc(pr_addr_cyc),
        .pr_wdata(pr_wdata), .pr_ack(pr_ack), .pr_err(pr_err), .pr_rdata(pr_rdata)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] exp_ctl;
    logic       exp_tmo;
    int         exp_cu, exp_du, cu_cnt, du_cnt;
    int         cur_tmo;

    // peripheral model state
    int         pm_delay, pm_err_at, pm_silent_at, pm_cnt, pm_byte;
    logic [7:0] pm_src [0:3];
    int         log_n;
    logic [7:0] log_d  [0:7];
    logic       log_ac [0:7];
    logic       log_wr [0:7];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit f_legal(input logic [7:0] c, input logic wr);
        return (c & 8'h2F) == (wr ? 8'h04 : 8'h24);
    endfunction

    function automatic int f_nbytes(input logic [2:0] a, input logic [1:0] sz);
        if (a == 3'd3) return 1;
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    always @(negedge clk) begin
        if (ctl_upd) cu_cnt++;
        if (dir_upd) du_cnt++;
        if (pr_ack) begin
            pr_ack = 1'b0;
            pr_err = 1'b0;
            pm_cnt = 0;
            pm_byte++;
        end else if (pr_req) begin
            if (pm_byte != pm_silent_at && pm_cnt == pm_delay) begin
                pr_ack   = 1'b1;
                pr_err   = (pm_byte == pm_err_at);
                pr_rdata = pm_src[pm_byte % 4];
                if (log_n < 8) begin
                    log_d[log_n]  = pr_wdata;
                    log_ac[log_n] = pr_addr_cyc;
                    log_wr[log_n] = pr_wr;
                end
                log_n++;
            end else begin
                pm_cnt++;
            end
        end
    end

    task automatic prep_pm(input int d, input int ea, input int sa);
        pm_delay = d; pm_err_at = ea; pm_silent_at = sa;
        pm_cnt = 0; pm_byte = 0; log_n = 0;
        for (int k = 0; k < 4; k++) pm_src[k] = 8'($urandom);
    endtask

    task automatic access(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int guard;
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        guard = 0;
        while (!cpu_done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) chk("R1 done pulse missing", 32'd0, 32'd1);
        rd = cpu_rdata;
    endtask

    task automatic sts_check(input string tag);
        logic [31:0] rd;
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk(tag, rd, {24'd0, line_sts, exp_tmo});
    endtask

    task automatic ctl_write(input logic [7:0] v);
        logic [31:0] rd;
        access(1'b1, 3'd2, 2'd0, {24'hABCDEF, v}, rd);
        if (v != exp_ctl) begin
            exp_cu++;
            if (v[5] != exp_ctl[5]) exp_du++;
            exp_ctl = v;
        end
        @(negedge clk);
        chk("R8 ctl_upd count", cu_cnt, exp_cu);
        chk("R9 dir_upd count", du_cnt, exp_du);
        chk("R8 ctl_val", ctl_val, exp_ctl & 8'hDF);
        chk("R9 dir_val", dir_val, exp_ctl[5]);
    endtask

    task automatic epp_op(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input int d, input int ea, input int sa);
        logic [31:0] rd, exp_rd;
        int n, exp_log, lim;
        bit fail;
        prep_pm(d, ea, sa);
        access(wr, a, sz, wd, rd);
        @(negedge clk);
        n = f_nbytes(a, sz);
        exp_rd = '1; exp_log = 0; fail = 0;
        if (f_legal(exp_ctl, wr)) begin
            for (int k = 0; k < n && !fail; k++) begin
                lim = (k == 0) ? d : d + 1;
                if (k == sa || lim > cur_tmo) fail = 1;
                else begin
                    exp_log++;
                    if (k == ea) fail = 1;
                    else if (!wr) exp_rd[k*8 +: 8] = pm_src[k];
                end
            end
        end
        if (fail) exp_tmo = 1'b1;
        chk(wr ? "R2 write byte count" : "R3 read byte count", log_n, exp_log);
        for (int k = 0; k < exp_log && k < 8 && k < log_n; k++) begin
            chk("R4 cycle kind", log_ac[k], (a == 3'd3));
            chk(wr ? "R2 transfer direction" : "R3 transfer direction", log_wr[k], wr);
            if (wr) chk("R5 write byte order", log_d[k], wd[k*8 +: 8]);
        end
        if (!wr) chk("R5 R6 read assembly", rd, exp_rd);
        sts_check("R6 timeout flag after transfer");
    endtask

    function automatic logic [7:0] pick_ctl();
        case ($urandom_range(0, 6))
            0: return 8'h04;
            1: return 8'h24;
            2: return 8'h14;
            3: return 8'h34;
            4: return 8'h0C;
            5: return 8'h25;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] v;
        int          sel, guard;
        void'($urandom(32'd20240611));
        rst = 1'b1; cfg_timeout = 16'd6; cur_tmo = 6;
        cpu_req = 0; cpu_wr = 0; cpu_addr = 0; cpu_size = 0; cpu_wdata = 0;
        line_sts = 7'b1011010;
        pr_ack = 0; pr_err = 0; pr_rdata = 0;
        cu_cnt = 0; du_cnt = 0; exp_cu = 0; exp_du = 0;
        exp_ctl = 8'h0C; exp_tmo = 1'b0;
        prep_pm(0, 9, 9);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R10 ready after reset", cpu_ready, 1'b1);
        chk("R2 no request after reset", pr_req, 1'b0);
        chk("R8 ctl_val after reset", ctl_val, 8'h0C);
        sts_check("R7 status after reset");
        access(1'b0, 3'd2, 2'd0, 32'd0, rd);
        chk("R8 control read after reset", rd, 32'h0000_000C);

        // unused offsets
        access(1'b0, 3'd6, 2'd0, 32'd0, rd);
        chk("R1 unused offset read", rd, 32'hFFFF_FFFF);
        access(1'b0, 3'd0, 2'd0, 32'd0, rd);
        chk("R1 offset zero read", rd, 32'hFFFF_FFFF);

        // refused write at reset control
        epp_op(1'b1, 3'd4, 2'd2, 32'h1122_3344, 0, 9, 9);

        // legal write pattern, address slot ignores size
        ctl_write(8'h04);
        epp_op(1'b1, 3'd3, 2'd2, 32'h0000_005A, 0, 9, 9);
        epp_op(1'b1, 3'd4, 2'd2, 32'hA1B2_C3D4, 1, 9, 9);
        epp_op(1'b1, 3'd4, 2'd1, 32'h0000_BEEF, 0, 9, 9);
        // read under write pattern is refused
        epp_op(1'b0, 3'd4, 2'd2, 32'd0, 0, 9, 9);

        // bits outside the mask do not matter; strobe bit does
        ctl_write(8'h14);
        epp_op(1'b1, 3'd4, 2'd0, 32'h0000_0077, 0, 9, 9);
        ctl_write(8'h05);
        epp_op(1'b1, 3'd4, 2'd0, 32'h0000_0066, 0, 9, 9);

        // read pattern, direction flips
        ctl_write(8'h24);
        epp_op(1'b0, 3'd4, 2'd1, 32'd0, 0, 9, 9);
        epp_op(1'b0, 3'd3, 2'd0, 32'd0, 2, 9, 9);
        // failure on inner byte of a word read
        epp_op(1'b0, 3'd4, 2'd2, 32'd0, 0, 2, 9);

        // sticky flag
        access(1'b1, 3'd1, 2'd0, 32'h0000_00FE, rd);
        sts_check("R7 bit0 clear write keeps flag");
        access(1'b1, 3'd1, 2'd0, 32'h0000_0001, rd);
        exp_tmo = 1'b0;
        sts_check("R7 bit0 set write clears flag");

        // timeout boundary
        cfg_timeout = 16'd3; cur_tmo = 3;
        epp_op(1'b0, 3'd3, 2'd0, 32'd0, 3, 9, 9);
        epp_op(1'b0, 3'd3, 2'd0, 32'd0, 4, 9, 9);
        epp_op(1'b0, 3'd4, 2'd2, 32'd0, 0, 9, 1);
        access(1'b1, 3'd1, 2'd0, 32'h0000_0001, rd);
        exp_tmo = 1'b0;

        // same-value control write
        ctl_write(8'h24);
        ctl_write(8'h24);

        // busy stall: a control write held during a transfer is not taken
        ctl_write(8'h04);
        cfg_timeout = 16'd20; cur_tmo = 20;
        prep_pm(8, 9, 9);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 3'd4; cpu_size = 2'd2; cpu_wdata = 32'h0102_0304;
        @(negedge clk);
        cpu_addr = 3'd2; cpu_wdata = 32'h0000_003F;
        chk("R10 ready low while busy", cpu_ready, 1'b0);
        guard = 0;
        while (!cpu_done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        cpu_req = 1'b0;
        @(negedge clk);
        chk("R10 held request not taken", ctl_val, 8'h04);
        chk("R10 no control pulse", cu_cnt, exp_cu);
        chk("R4 word write byte count", log_n, 4);

        // random mix
        cfg_timeout = 16'd6; cur_tmo = 6;
        for (int it = 0; it < 300; it++) begin
            sel = $urandom_range(0, 9);
            if (sel < 2) begin
                ctl_write(pick_ctl());
            end else if (sel == 2) begin
                v = $urandom;
                access(1'b1, 3'd1, 2'd0, v, rd);
                if (v[0]) exp_tmo = 1'b0;
                sts_check("R7 random status write");
            end else if (sel == 3) begin
                access(1'b0, 3'd2, 2'd0, 32'd0, rd);
                chk("R8 random control read", rd, {24'd0, exp_ctl});
            end else begin
                epp_op(1'($urandom), ($urandom_range(0, 1) == 0) ? 3'd3 : 3'd4,
                       2'($urandom), $urandom,
                       $urandom_range(0, 2),
                       ($urandom_range(0, 5) == 0) ? $urandom_range(0, 3) : 9,
                       ($urandom_range(0, 7) == 0) ? $urandom_range(0, 3) : 9);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule